// File: doc/BRIEF.md
# Exception Vector Fetch Sequencer

This block converts an accepted exception into the memory reads that give the core its handler address. A request carries an 8-bit vector number. The number comes either from an internal exception source or from an external device that supplies it during interrupt acknowledge, and a select input picks between the two. The block scales the number by four, adds it to a programmable table base and issues one 32-bit read on a request/acknowledge bus. An address-space code is driven with each read. The word that comes back is presented to the core as the handler address.

A reset request runs a separate two-read sequence from fixed addresses in program space. The first word read is the initial stack pointer and the second is the initial program counter. A bus error on any read ends the sequence with a fault pulse. Software may rewrite the table base at any time, for example on a task switch. A request uses the base that was in effect when the request was accepted.

Top module: `evf_vector_fetch`

## Requirements
- R1: While rst_ni is low and after it rises, ready_o is 1 and bus_req_o, done_o, fault_o and rst_seq_o are 0. The table base is 0.
- R2: A write with vbr_we_i stores vbr_wdata_i with bits [1:0] forced to 0. The new value applies to requests accepted on later clock edges. A fetch already in progress keeps its address.
- R3: A non-reset fetch address is table base + 4 × vector, modulo 2^32. The vector is ext_vec_i when src_ext_i is 1 and int_vec_i when src_ext_i is 0.
- R4: A non-reset fetch drives bus_fc_o = 3'b101 (supervisor data).
- R5: A reset request (exc_reset_i = 1) reads address 0x0 and then address 0x4, whatever the table base is. Both reads drive bus_fc_o = 3'b110 (supervisor program). The first word goes to sp_o and the second goes to handler_o.
- R6: Once a read starts, bus_req_o, bus_addr_o and bus_fc_o hold steady until the clock edge that samples bus_ack_i or bus_err_i high.
- R7: On the clock edge that samples the acknowledge of the final read, the block releases bus_req_o. On that same edge, done_o rises for exactly one cycle, together with handler_o. For a reset sequence, rst_seq_o = 1 and sp_o are valid during that cycle.
- R8: If bus_err_i is sampled high during any read, the sequence aborts and bus_req_o drops. fault_o then pulses for one cycle and done_o does not pulse. bus_err_i takes precedence over a simultaneous bus_ack_i.
- R9: A request is accepted only while ready_o = 1, which means no sequence is running. A request raised while a sequence runs is ignored and starts no further read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vbr_we_i | input | 1 | Table base write enable |
| vbr_wdata_i | input | 32 | Table base write data |
| exc_req_i | input | 1 | Exception request |
| exc_reset_i | input | 1 | Request is the reset sequence |
| src_ext_i | input | 1 | 1: use ext_vec_i, 0: use int_vec_i |
| int_vec_i | input | 8 | Vector from an internal source |
| ext_vec_i | input | 8 | Vector from an external device |
| ready_o | output | 1 | Idle, able to accept a request |
| bus_req_o | output | 1 | Read request |
| bus_addr_o | output | 32 | Read address |
| bus_fc_o | output | 3 | Address-space code |
| bus_rdata_i | input | 32 | Read data |
| bus_ack_i | input | 1 | Read acknowledge |
| bus_err_i | input | 1 | Read bus error |
| done_o | output | 1 | Handler address valid, one-cycle pulse |
| handler_o | output | 32 | Fetched handler address |
| sp_o | output | 32 | Fetched initial stack pointer |
| rst_seq_o | output | 1 | Completed sequence was reset |
| fault_o | output | 1 | Sequence aborted by bus error, one-cycle pulse |

## Verification
The clock edge that accepts a request also puts the first read on the bus, so the bench expects the address one cycle after the request is raised. In a reset sequence, the second address follows one cycle after the first acknowledge. The done_o or fault_o pulse appears in the cycle after the final acknowledge or error edge. The bench drives every input and samples every output at the falling clock edge. It therefore compares each expected value in the cycle in which it becomes due, and it confirms in the following cycle that each pulse has ended. Wait states on the bus are randomised, so the hold checks run over holds of several lengths.

// File: rtl/evf_pkg.sv
package evf_pkg;
  localparam int ADDR_W = 32;
  localparam int FC_W   = 3;
  localparam logic [FC_W-1:0] FC_SUP_DATA = 3'b101;
  localparam logic [FC_W-1:0] FC_SUP_PROG = 3'b110;
  localparam logic [ADDR_W-1:0] RST_SP_ADDR = 32'h0;
  localparam logic [ADDR_W-1:0] RST_PC_ADDR = 32'h4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SP   = 2'd1,
    ST_PC   = 2'd2,
    ST_VEC  = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/evf_vbr.sv
module evf_vbr #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] vbr_o
);
  localparam int ALIGN = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   vbr_o <= '0;
    else if (we_i) vbr_o <= wdata_i & ~ALIGN_MASK;
  end

  assert_vbr_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> vbr_o == ($past(wdata_i) & ~ALIGN_MASK));
endmodule

// File: rtl/evf_addr_gen.sv
module evf_addr_gen
  import evf_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] vbr_i,
  input  logic              is_reset_i,
  input  logic              src_ext_i,
  input  logic [VEC_W-1:0]  int_vec_i,
  input  logic [VEC_W-1:0]  ext_vec_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [FC_W-1:0]   fc_o
);
  localparam int SHIFT = $clog2(WORD_BYTES);
  localparam int PAD   = ADDR_W - VEC_W - SHIFT;

  logic [VEC_W-1:0]  vec_sel;
  logic [ADDR_W-1:0] offset;

  assign vec_sel = src_ext_i ? ext_vec_i : int_vec_i;

  generate
    if (SHIFT == 0) begin : g_noscale
      assign offset = {{PAD{1'b0}}, vec_sel};
    end else begin : g_scale
      assign offset = {{PAD{1'b0}}, vec_sel, {SHIFT{1'b0}}};
    end
  endgenerate

  // reset entry is absolute, never relative to the base
  assign addr_o = is_reset_i ? RST_SP_ADDR : vbr_i + offset;
  assign fc_o   = is_reset_i ? FC_SUP_PROG : FC_SUP_DATA;
endmodule

// File: rtl/evf_fetch_fsm.sv
module evf_fetch_fsm
  import evf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              is_reset_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [FC_W-1:0]   start_fc_i,
  output logic              ready_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [FC_W-1:0]   bus_fc_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  output logic              done_o,
  output logic [DATA_W-1:0] handler_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              rst_seq_o,
  output logic              fault_o
);
  fetch_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [FC_W-1:0]   fc_q;
  logic [DATA_W-1:0] sp_q, handler_q;
  logic              done_q, fault_q, rst_seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      fc_q      <= '0;
      sp_q      <= '0;
      handler_q <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      rst_seq_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          addr_q    <= start_addr_i;
          fc_q      <= start_fc_i;
          rst_seq_q <= is_reset_i;
          state_q   <= is_reset_i ? ST_SP : ST_VEC;
        end
        ST_SP: if (bus_err_i) begin
          fault_q <= 1'b1;
          state_q <= ST_IDLE;
        end else if (bus_ack_i) begin
          sp_q    <= bus_rdata_i;
          addr_q  <= RST_PC_ADDR;
          state_q <= ST_PC;
        end
        default: if (bus_err_i) begin
          fault_q <= 1'b1;
          state_q <= ST_IDLE;
        end else if (bus_ack_i) begin
          handler_q <= bus_rdata_i;
          done_q    <= 1'b1;
          state_q   <= ST_IDLE;
        end
      endcase
    end
  end

  assign ready_o    = state_q == ST_IDLE;
  assign bus_req_o  = state_q != ST_IDLE;
  assign bus_addr_o = addr_q;
  assign bus_fc_o   = fc_q;
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign handler_o  = handler_q;
  assign sp_o       = sp_q;
  assign rst_seq_o  = done_q & rst_seq_q;

  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !bus_err_i |=>
      bus_req_o && $stable(bus_addr_o) && $stable(bus_fc_o));

  assert_data_space_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !rst_seq_q |-> bus_fc_o == FC_SUP_DATA);

  assert_reset_second_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_SP && bus_ack_i && !bus_err_i |=>
      bus_req_o && bus_addr_o == RST_PC_ADDR && bus_fc_o == FC_SUP_PROG);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fault_abort_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_err_i |=> fault_o && !done_o && !bus_req_o);

  assert_busy_ignore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_o && !$past(bus_req_o) |-> !done_o && !fault_o);
endmodule

// File: rtl/evf_vector_fetch.sv
module evf_vector_fetch
  import evf_pkg::*;
#(
  parameter int VEC_W      = 8,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vbr_we_i,
  input  logic [ADDR_W-1:0] vbr_wdata_i,
  input  logic              exc_req_i,
  input  logic              exc_reset_i,
  input  logic              src_ext_i,
  input  logic [VEC_W-1:0]  int_vec_i,
  input  logic [VEC_W-1:0]  ext_vec_i,
  output logic              ready_o,
  output logic              bus_req_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [FC_W-1:0]   bus_fc_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_ack_i,
  input  logic              bus_err_i,
  output logic              done_o,
  output logic [DATA_W-1:0] handler_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              rst_seq_o,
  output logic              fault_o
);
  logic [ADDR_W-1:0] vbr, start_addr;
  logic [FC_W-1:0]   start_fc;

  evf_vbr #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_vbr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (vbr_we_i),
    .wdata_i (vbr_wdata_i),
    .vbr_o   (vbr)
  );

  evf_addr_gen #(.VEC_W(VEC_W), .WORD_BYTES(WORD_BYTES)) u_addr (
    .vbr_i      (vbr),
    .is_reset_i (exc_reset_i),
    .src_ext_i  (src_ext_i),
    .int_vec_i  (int_vec_i),
    .ext_vec_i  (ext_vec_i),
    .addr_o     (start_addr),
    .fc_o       (start_fc)
  );

  evf_fetch_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (exc_req_i),
    .is_reset_i   (exc_reset_i),
    .start_addr_i (start_addr),
    .start_fc_i   (start_fc),
    .ready_o      (ready_o),
    .bus_req_o    (bus_req_o),
    .bus_addr_o   (bus_addr_o),
    .bus_fc_o     (bus_fc_o),
    .bus_rdata_i  (bus_rdata_i),
    .bus_ack_i    (bus_ack_i),
    .bus_err_i    (bus_err_i),
    .done_o       (done_o),
    .handler_o    (handler_o),
    .sp_o         (sp_o),
    .rst_seq_o    (rst_seq_o),
    .fault_o      (fault_o)
  );

  assert_vec_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && exc_req_i && !exc_reset_i |=>
      bus_addr_o == $past(vbr) + {22'd0, $past(src_ext_i ? ext_vec_i : int_vec_i), 2'b00});

  assert_reset_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && exc_req_i && exc_reset_i |=>
      bus_addr_o == RST_SP_ADDR && bus_fc_o == FC_SUP_PROG);
endmodule

// File: tb/evf_vector_fetch_tb.sv
module evf_vector_fetch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vbr_we = 1'b0;
  logic [31:0] vbr_wdata = '0;
  logic        exc_req = 1'b0, exc_reset = 1'b0, src_ext = 1'b0;
  logic [7:0]  int_vec = '0, ext_vec = '0;
  logic        ready, bus_req, done, rst_seq, fault;
  logic [31:0] bus_addr, handler, sp;
  logic [2:0]  bus_fc;
  logic [31:0] bus_rdata = '0;
  logic        bus_ack = 1'b0, bus_err = 1'b0;

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit finished = 1'b0;
  logic [31:0] vbr_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evf_vector_fetch u_dut (
    .clk_i(clk), .rst_ni(rst_n), .vbr_we_i(vbr_we), .vbr_wdata_i(vbr_wdata),
    .exc_req_i(exc_req), .exc_reset_i(exc_reset), .src_ext_i(src_ext),
    .int_vec_i(int_vec), .ext_vec_i(ext_vec), .ready_o(ready),
    .bus_req_o(bus_req), .bus_addr_o(bus_addr), .bus_fc_o(bus_fc),
    .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack), .bus_err_i(bus_err),
    .done_o(done), .handler_o(handler), .sp_o(sp), .rst_seq_o(rst_seq),
    .fault_o(fault)
  );

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h1357_9bdf;
  endfunction

  function automatic logic [31:0] vec_addr(logic [31:0] base, logic [7:0] v);
    return base + {22'd0, v, 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic write_vbr(logic [31:0] d);
    @(negedge clk);
    vbr_we = 1'b1; vbr_wdata = d;
    @(negedge clk);
    vbr_we = 1'b0;
    vbr_m = d & ~32'h3;
  endtask

  // err_at: 0 none, else index (1-based) of read that errors
  task automatic run_exc(bit rst, bit ext, logic [7:0] vi, logic [7:0] ve,
                         int err_at, int lat, bit poke, bit both);
    logic [31:0] a_exp, last_a;
    int nf;
    @(negedge clk);
    exc_req = 1'b1; exc_reset = rst; src_ext = ext; int_vec = vi; ext_vec = ve;
    @(negedge clk);
    exc_req = 1'b0;
    nf = rst ? 2 : 1;
    last_a = '0;
    for (int k = 0; k < nf; k++) begin
      if (rst) a_exp = (k == 0) ? 32'h0 : 32'h4;
      else     a_exp = vec_addr(vbr_m, ext ? ve : vi);
      last_a = a_exp;
      chk(rst ? "R5 addr" : "R3 addr", bus_addr, a_exp);
      chk(rst ? "R5 fc" : "R4 fc", {29'd0, bus_fc}, rst ? 32'd6 : 32'd5);
      chk("R9 busy", {30'd0, bus_req, ready}, 32'd2);
      for (int w = 0; w < lat; w++) begin
        if (poke && w == 0) begin
          exc_req = 1'b1; int_vec = ~vi; ext_vec = ~ve; exc_reset = ~rst;
          vbr_we = 1'b1; vbr_wdata = $urandom;
        end
        @(negedge clk);
        exc_req = 1'b0;
        if (vbr_we) begin vbr_m = vbr_wdata & ~32'h3; vbr_we = 1'b0; end
        chk("R6 hold addr", bus_addr, a_exp);
        chk("R6 hold req", {31'd0, bus_req}, 32'd1);
      end
      bus_rdata = mem_word(a_exp);
      if (k + 1 == err_at) begin bus_err = 1'b1; bus_ack = both; end
      else bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0; bus_err = 1'b0; bus_rdata = '0;
      if (k + 1 == err_at) begin
        chk("R8 fault", {29'd0, fault, done, bus_req}, 32'd4);
        @(negedge clk);
        chk("R8 fault pulse", {31'd0, fault}, 32'd0);
        chk("R9 no restart", {31'd0, bus_req}, 32'd0);
        return;
      end
    end
    chk("R7 done", {29'd0, done, bus_req, fault}, 32'd4);
    chk("R7 handler", handler, mem_word(last_a));
    chk("R7 rst flag", {31'd0, rst_seq}, {31'd0, rst});
    if (rst) chk("R5 sp", sp, mem_word(32'h0));
    @(negedge clk);
    chk("R7 pulse", {31'd0, done}, 32'd0);
    chk("R9 no restart", {31'd0, bus_req}, 32'd0);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG && !finished) begin
        n_fail++;
        $display("FAIL watchdog: actual %0d expected <%0d cycles", cycles, WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin : main
    void'($urandom(32'd4242));
    #(3*CLK_PERIOD + 2);
    @(negedge clk);
    chk("R1 reset", {28'd0, ready, bus_req, done, fault}, 32'd8);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle", {27'd0, ready, bus_req, done, fault, rst_seq}, 32'd16);
    // base is zero after reset: vector 5 at 0x14
    run_exc(1'b0, 1'b0, 8'd5, 8'd9, 0, 0, 1'b0, 1'b0);
    // R2 alignment of written base
    write_vbr(32'h1000_0003);
    run_exc(1'b0, 1'b1, 8'd1, 8'd0, 0, 1, 1'b0, 1'b0);
    run_exc(1'b0, 1'b0, 8'hff, 8'd0, 0, 2, 1'b0, 1'b0);
    // R3 wrap modulo 2^32
    write_vbr(32'hffff_fffc);
    run_exc(1'b0, 1'b1, 8'd0, 8'd2, 0, 0, 1'b0, 1'b0);
    // R5 reset sequence ignores base
    write_vbr(32'h8000_0400);
    run_exc(1'b1, 1'b0, 8'd7, 8'd7, 0, 1, 1'b0, 1'b0);
    // R2/R9 write and new request during a fetch
    run_exc(1'b0, 1'b0, 8'd3, 8'd4, 0, 2, 1'b1, 1'b0);
    run_exc(1'b0, 1'b1, 8'd3, 8'd4, 0, 0, 1'b0, 1'b0);
    // R8 errors: on vector read, on each reset read, with simultaneous ack
    run_exc(1'b0, 1'b0, 8'd10, 8'd0, 1, 1, 1'b0, 1'b0);
    run_exc(1'b1, 1'b0, 8'd0, 8'd0, 1, 0, 1'b0, 1'b1);
    run_exc(1'b1, 1'b0, 8'd0, 8'd0, 2, 2, 1'b0, 1'b1);
    run_exc(1'b0, 1'b1, 8'd0, 8'd33, 1, 0, 1'b0, 1'b1);
    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(3) == 0) write_vbr($urandom);
      run_exc($urandom_range(9) == 0, 1'($urandom_range(1)),
              8'($urandom), 8'($urandom),
              ($urandom_range(7) == 0) ? 1 : 0,
              $urandom_range(3), 1'($urandom_range(1)), 1'($urandom_range(1)));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule